// File: doc/BRIEF.md
# Ones Density Monitor and Enforcer

This block watches a serial T1 bit stream, one bit per cycle in which a bit-enable strobe is high, and checks it against two ones-density rules. The first rule limits runs of zeros: no more than fifteen zeros may follow one another. The second is a family of sliding-window rules checked in parallel: for each N from 1 to 23, every span of 8·(N+1) consecutive bits must hold at least N ones. Each rule has its own sticky flag. A host clears both flags with a one-cycle clear pulse.

One instance sits on each direction of a line, so receive and transmit violations are reported separately. On the transmit side an enforce input may be raised. The block then replaces a zero with a one whenever passing that zero would break either rule, so the outgoing stream stays compliant whatever data arrives. Enforcement is meant to stay off when the line uses a zero-substitution code, because such data already meets the rules. The checked stream is always the outgoing one. Bits sent before reset count as ones.

Top module: `ones_density_guard`

## Requirements
- R1: After reset, `dout`, `zero_flag` and `dens_flag` are all 0.
- R2: With `enf_en` low, each bit taken on a clock edge with `bit_en` high appears unchanged on `dout` after that edge.
- R3: In a cycle with `bit_en` low, `dout` and the rule state do not change, and neither flag is set. A following accepted bit is judged as if the idle cycles had not happened.
- R4: `zero_flag` sets on the edge that accepts the sixteenth zero in a row of the outgoing stream. A run of fifteen zeros does not set it.
- R5: `dens_flag` sets on the edge that accepts a bit after which some window holds too few ones. A window here is the most recent 8·(N+1) outgoing bits, for some N from 1 to 23, and too few means fewer than N ones. Positions before reset count as ones.
- R6: Both flags are sticky. A `viol_clr` pulse clears them, but a violation in the same cycle as the pulse leaves its flag set.
- R7: With `enf_en` held high since reset, an incoming zero goes out as a one exactly when passing the zero would break R4's or R5's rule on that bit. Neither flag ever sets.
- R8: An incoming one always goes out as a one, whether or not enforcement is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Accept `din` as the next stream bit on this edge |
| din | input | 1 | Incoming serial bit |
| enf_en | input | 1 | Enable ones insertion |
| viol_clr | input | 1 | One-cycle pulse that clears both flags |
| dout | output | 1 | Outgoing serial bit, registered |
| zero_flag | output | 1 | Sticky excess-zeros violation |
| dens_flag | output | 1 | Sticky window-density violation |

## Verification
The assertion that enforcement never raises a flag assumes that `enf_en` is high from reset, or at least that the stream was compliant when enforcement was switched on. If an earlier window was already short, a single forced one cannot always restore it. The stimulus therefore resets the block before every enforced scenario and never toggles `enf_en` inside one. The remaining properties make no assumption about `din`, `bit_en` or `viol_clr`. The bench drives every input at the falling edge, so each input is stable around the rising edge.

// File: rtl/odm_pkg.sv
package odm_pkg;
    // Default geometry of the density rules
    localparam int unsigned ODM_UNIT    = 8;   // window grows in steps of this many bits
    localparam int unsigned ODM_NMAX    = 23;  // largest N checked
    localparam int unsigned ODM_RUN_MAX = 15;  // longest legal zero run

    typedef struct packed {
        logic dout;
        logic zero_flag;
        logic dens_flag;
    } odm_out_t;
endpackage

// File: rtl/odm_zero_run.sv
// Counts consecutive zeros of the outgoing stream (saturating).
module odm_zero_run #(
    parameter int unsigned RUN_MAX = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic bit_i,
    output logic at_edge_o   // one more zero would exceed RUN_MAX
);
    localparam int unsigned ZW = $clog2(RUN_MAX + 2);
    localparam logic [ZW-1:0] SAT = ZW'(RUN_MAX + 1);
    localparam logic [ZW-1:0] LIM = ZW'(RUN_MAX);

    logic [ZW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (adv_i) begin
            if (bit_i)           run_d = '0;
            else if (run_q != SAT) run_d = run_q + ZW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign at_edge_o = (run_q >= LIM);
endmodule

// File: rtl/odm_window.sv
// History of the outgoing stream plus one running ones count per window length.
module odm_window #(
    parameter int unsigned UNIT = 8,
    parameter int unsigned NMAX = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            bit_i,
    output logic [NMAX-1:0] zero_short_o,  // a zero now leaves window n short
    output logic [NMAX-1:0] short_o        // bit_i now leaves window n short
);
    localparam int unsigned HIST = UNIT * (NMAX + 1);
    localparam int unsigned CW   = $clog2(HIST + 1);

    typedef struct packed {
        logic [HIST-1:0]          hist;
        logic [NMAX-1:0][CW-1:0]  cnt;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [CW-1:0] rem_w [NMAX];

    function automatic win_st_t init_st();
        win_st_t s;
        s.hist = '1;
        for (int i = 0; i < int'(NMAX); i++) s.cnt[i] = CW'(UNIT * (i + 2));
        return s;
    endfunction

    for (genvar n = 0; n < int'(NMAX); n++) begin : g_win
        localparam int unsigned   LEN  = UNIT * (n + 2);
        localparam logic [CW-1:0] NEED = CW'(n + 1);
        logic leave;
        assign leave           = st_q.hist[LEN-1];
        assign rem_w[n]        = st_q.cnt[n] - {{(CW-1){1'b0}}, leave};
        assign zero_short_o[n] = (rem_w[n] < NEED);
        assign short_o[n]      = ((rem_w[n] + {{(CW-1){1'b0}}, bit_i}) < NEED);
    end

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.hist = {st_q.hist[HIST-2:0], bit_i};
            for (int i = 0; i < int'(NMAX); i++)
                st_d.cnt[i] = rem_w[i] + {{(CW-1){1'b0}}, bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= init_st();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ones_density_guard.sv
module ones_density_guard
    import odm_pkg::*;
#(
    parameter int unsigned UNIT    = ODM_UNIT,
    parameter int unsigned NMAX    = ODM_NMAX,
    parameter int unsigned RUN_MAX = ODM_RUN_MAX
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic din,
    input  logic enf_en,
    input  logic viol_clr,
    output logic dout,
    output logic zero_flag,
    output logic dens_flag
);
    odm_out_t out_d, out_q;

    logic            run_edge;
    logic [NMAX-1:0] zero_short;
    logic [NMAX-1:0] short_now;
    logic            force_one;
    logic            obit;
    logic            run_bad;
    logic            dens_bad;

    // Decision uses only registered state, so no combinational loop.
    assign force_one = enf_en & ~din & (run_edge | (|zero_short));
    assign obit      = din | force_one;
    assign run_bad   = bit_en & ~obit & run_edge;
    assign dens_bad  = bit_en & (|short_now);

    odm_zero_run #(.RUN_MAX(RUN_MAX)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (bit_en),
        .bit_i     (obit),
        .at_edge_o (run_edge)
    );

    odm_window #(.UNIT(UNIT), .NMAX(NMAX)) u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_i        (bit_en),
        .bit_i        (obit),
        .zero_short_o (zero_short),
        .short_o      (short_now)
    );

    always_comb begin
        out_d           = out_q;
        if (bit_en) out_d.dout = obit;
        out_d.zero_flag = (out_q.zero_flag & ~viol_clr) | run_bad;
        out_d.dens_flag = (out_q.dens_flag & ~viol_clr) | dens_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout      = out_q.dout;
    assign zero_flag = out_q.zero_flag;
    assign dens_flag = out_q.dens_flag;
endmodule

// File: rtl/ones_density_guard_chk.sv
module ones_density_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic din,
    input logic enf_en,
    input logic viol_clr,
    input logic dout,
    input logic zero_flag,
    input logic dens_flag
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!dout && !zero_flag && !dens_flag);
        end
    end

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !enf_en) |=> (dout == $past(din)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !viol_clr) |=> ($stable(dout) && $stable(zero_flag) && $stable(dens_flag)));

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_clr && !bit_en) |=> (!zero_flag && !dens_flag));

    assert_sticky_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag && !viol_clr) |=> zero_flag);

    assert_sticky_dens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dens_flag && !viol_clr) |=> dens_flag);

    assert_enf_no_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && enf_en && !zero_flag) |=> !zero_flag);

    assert_enf_no_dens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && enf_en && !dens_flag) |=> !dens_flag);

    assert_ones_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && din) |=> dout);
endmodule

bind ones_density_guard ones_density_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .din       (din),
    .enf_en    (enf_en),
    .viol_clr  (viol_clr),
    .dout      (dout),
    .zero_flag (zero_flag),
    .dens_flag (dens_flag)
);

// File: tb/ones_density_guard_tb_top.sv
`timescale 1ns/1ps
module ones_density_guard_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, din = 1'b0, enf_en = 1'b0, viol_clr = 1'b0;
    logic dout, zero_flag, dens_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    ones_density_guard dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din), .enf_en(enf_en),
        .viol_clr(viol_clr), .dout(dout), .zero_flag(zero_flag), .dens_flag(dens_flag)
    );

    // Reference model built from the requirements
    bit m_bits [0:8191];
    int m_pos;
    int m_zrun;
    bit m_zf, m_df, m_dout;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int win_ones(int len, bit cand);
        int ones = cand ? 1 : 0;
        for (int k = 1; k < len; k++) begin
            int idx = m_pos - k;
            if (idx < 0) ones++;
            else if (m_bits[idx]) ones++;
        end
        return ones;
    endfunction

    function automatic bit any_short(bit cand);
        bit s = 0;
        for (int n = 1; n <= 23; n++)
            if (win_ones(8 * (n + 1), cand) < n) s = 1;
        return s;
    endfunction

    task automatic model_reset();
        m_pos = 0; m_zrun = 0; m_zf = 0; m_df = 0; m_dout = 0;
    endtask

    task automatic check(string tag, bit ok, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bit_en = 0; din = 0; viol_clr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    // Send one bit (optionally with a clear pulse) and compare all outputs.
    task automatic send_bit(bit b, bit clr, string tag);
        bit bad0, ob, runv, densv;
        @(negedge clk);
        din = b; bit_en = 1; viol_clr = clr;
        @(posedge clk);
        bad0  = (m_zrun + 1 > 15) || any_short(1'b0);
        ob    = b | (enf_en & ~b & bad0);
        runv  = !ob && (m_zrun + 1 > 15);
        densv = any_short(ob);
        m_zf  = (m_zf & ~clr) | runv;
        m_df  = (m_df & ~clr) | densv;
        m_bits[m_pos] = ob; m_pos++;
        m_zrun = ob ? 0 : m_zrun + 1;
        m_dout = ob;
        @(negedge clk);
        bit_en = 0; viol_clr = 0;
        check(tag, (dout == m_dout) && (zero_flag == m_zf) && (dens_flag == m_df),
              $sformatf("dout/zf/df=%0b%0b%0b exp=%0b%0b%0b at bit %0d",
                        dout, zero_flag, dens_flag, m_dout, m_zf, m_df, m_pos - 1));
    endtask

    function automatic bit rnd_bit(int one_in);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return (lfsr[3:0] < 4'(16 / one_in));
    endfunction

    task automatic t_reset_state();
        do_reset();
        check("R1", dout == 0 && zero_flag == 0 && dens_flag == 0,
              $sformatf("dout/zf/df=%0b%0b%0b exp=000", dout, zero_flag, dens_flag));
    endtask

    task automatic t_pass_through();
        do_reset(); enf_en = 0;
        for (int i = 0; i < 300; i++) send_bit(rnd_bit(2), 0, "R2");
    endtask

    task automatic t_idle_hold();
        logic d0, z0, f0;
        do_reset(); enf_en = 0;
        for (int i = 0; i < 20; i++) send_bit(1'b0, 0, "R3");  // sets both flags
        send_bit(1'b1, 0, "R3");
        d0 = dout; z0 = zero_flag; f0 = dens_flag;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); din = ~din;
        end
        check("R3", dout == d0 && zero_flag == z0 && dens_flag == f0,
              $sformatf("dout/zf/df=%0b%0b%0b exp=%0b%0b%0b", dout, zero_flag, dens_flag, d0, z0, f0));
        for (int i = 0; i < 10; i++) send_bit(1'b0, 0, "R3");
    endtask

    task automatic t_zero_run();
        do_reset(); enf_en = 0;
        send_bit(1'b1, 0, "R4");
        for (int i = 0; i < 15; i++) send_bit(1'b0, 0, "R4");
        check("R4", zero_flag == 0, $sformatf("zf=%0b exp=0 after 15 zeros", zero_flag));
        send_bit(1'b0, 0, "R4");
        check("R4", zero_flag == 1, $sformatf("zf=%0b exp=1 after 16 zeros", zero_flag));
    endtask

    task automatic t_clear();
        do_reset(); enf_en = 0;
        for (int i = 0; i < 17; i++) send_bit(1'b0, 0, "R6");
        send_bit(1'b1, 0, "R6");
        check("R6", zero_flag && dens_flag, $sformatf("zf/df=%0b%0b exp=11 held", zero_flag, dens_flag));
        @(negedge clk); viol_clr = 1;
        @(negedge clk); viol_clr = 0;
        m_zf = 0; m_df = 0;
        check("R6", !zero_flag && !dens_flag, $sformatf("zf/df=%0b%0b exp=00 after clear", zero_flag, dens_flag));
        for (int i = 0; i < 15; i++) send_bit(1'b0, 0, "R6");
        send_bit(1'b0, 1, "R6");  // violation and clear in the same cycle
        check("R6", zero_flag == 1, $sformatf("zf=%0b exp=1 set beats clear", zero_flag));
    endtask

    task automatic t_density_periodic(int period, string tag);
        do_reset(); enf_en = 0;
        for (int i = 0; i < 400; i++) send_bit((i % period) == 0, 0, tag);
        check(tag, zero_flag == 0 && dens_flag == 1,
              $sformatf("period %0d zf/df=%0b%0b exp=01", period, zero_flag, dens_flag));
    endtask

    task automatic t_enforce(int one_in, int nbits);
        do_reset(); enf_en = 1;
        for (int i = 0; i < nbits; i++)
            send_bit(one_in == 0 ? 1'b0 : rnd_bit(one_in), 0, "R7");
        check("R7", zero_flag == 0 && dens_flag == 0,
              $sformatf("zf/df=%0b%0b exp=00 under enforcement", zero_flag, dens_flag));
        enf_en = 0;
    endtask

    task automatic t_ones_kept();
        do_reset(); enf_en = 1;
        for (int i = 0; i < 40; i++) begin
            send_bit(1'b1, 0, "R8");
            check("R8", dout == 1, $sformatf("dout=%0b exp=1", dout));
        end
        enf_en = 0;
        for (int i = 0; i < 40; i++) send_bit(1'b1, 0, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        t_reset_state();
        t_pass_through();
        t_idle_hold();
        t_zero_run();
        t_clear();
        t_density_periodic(15, "R5");   // short windows fail, zero runs stay legal
        t_density_periodic(9, "R5");    // only the longer windows fail
        t_enforce(0, 600);
        t_enforce(16, 1000);
        t_ones_kept();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule